// File: doc/BRIEF.md
# Flash Read-Data Source Selector

This block forms the byte returned on the read data lines of a flash-like device. The device mode picks the source. In array mode the stored array byte passes straight through. In autoselect mode the block returns an identification byte or a sector protection flag. While an embedded program or erase is running, it returns a status byte that software polls to detect completion.

The status byte carries three indications:
- a polling bit that depends on the data being programmed;
- a bit that inverts on every read strobe while the operation is busy;
- a bit that copies the time-limit flag.

Both identification bytes are built from 7-bit codes, with bit 7 computed as the odd-parity bit. The surrounding controller supplies the array byte, the byte being programmed, the protect vector and the done and timeout flags. It also raises a one-cycle strobe for every read.

Top module: `flash_rdmux`

## Requirements
- R1: With `mode_i` = 2'b00 (array read), `rd_data_o` equals `arr_data_i`.
- R2: With `mode_i` = 2'b01 (autoselect), a low address byte of 00h returns 01h and 01h returns A4h. Each ID byte has an odd number of ones, with bit 7 acting as the parity bit.
- R3: In autoselect, a low address byte of 02h returns bit 0 = `sect_prot_i[addr_i[18:16]]`, with bits 7..1 at 0.
- R4: In autoselect, any other low address byte returns 00h. Address bits 15..8 have no effect.
- R5: With `mode_i` = 2'b10 (program) and `op_done_i` = 0, bit 7 of `rd_data_o` is the complement of `prog_byte_i[7]`.
- R6: With `mode_i` = 2'b11 (erase) and `op_done_i` = 0, bit 7 of `rd_data_o` is 0.
- R7: While busy (mode 2'b10 or 2'b11 with `op_done_i` = 0), bit 6 of `rd_data_o` equals `toggle_o`. `toggle_o` inverts at each clock edge where `rd_stb_i` is 1.
- R8: While not busy, `toggle_o` holds its value and `rd_stb_i` is ignored.
- R9: While busy, bit 5 of `rd_data_o` equals `op_timeout_i` and bits 4..0 are 0.
- R10: In mode 2'b10 or 2'b11 with `op_done_i` = 1, `rd_data_o` equals `arr_data_i`.
- R11: After reset, `toggle_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 array, 01 autoselect, 10 program, 11 erase |
| addr_i | input | 19 | Read address |
| arr_data_i | input | 8 | Array byte at the read address |
| prog_byte_i | input | 8 | Byte being programmed |
| sect_prot_i | input | 8 | Per-sector protect flags |
| op_done_i | input | 1 | Embedded operation finished |
| op_timeout_i | input | 1 | Time limit exceeded |
| rd_stb_i | input | 1 | One-cycle read strobe |
| rd_data_o | output | 8 | Read data |
| toggle_o | output | 1 | Toggle-bit state |

## Verification
Array and done-fallback reads use several unrelated array bytes. This shows that the path is a real pass-through and not a constant.

Autoselect reads cover offsets 00h, 01h and 02h, plus an unused offset. Upper offset bits are set nonzero, and the protect vector is asymmetric, so a wrong sector field or a wrong offset decode gives a different byte.

Program polling uses target bytes with bit 7 both set and clear, which separates the complemented bit from a fixed value. Erase polling sets the timeout flag both ways. Toggle runs alternate strobes inside and outside busy, so a bit that flips while idle, or stays still while busy, is caught.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;
  localparam int DATA_W  = 8;
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TMO_BIT  = 5;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'b00,
    MODE_AUTOSEL = 2'b01,
    MODE_PROG    = 2'b10,
    MODE_ERASE   = 2'b11
  } rd_mode_e;

  function automatic logic [DATA_W-1:0] with_odd_par(input logic [DATA_W-2:0] code);
    return {~^code, code};
  endfunction
endpackage

// File: rtl/flash_id_src.sv
module flash_id_src
  import flash_rdmux_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SECT_W  = 3,
  parameter int OFFS_W  = 8,
  parameter logic [DATA_W-2:0] MFR_ID7 = 7'h01,
  parameter logic [DATA_W-2:0] DEV_ID7 = 7'h24
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [(1<<SECT_W)-1:0]   sect_prot_i,
  output logic [DATA_W-1:0]        id_data_o
);
  localparam int MID_W = ADDR_W - SECT_W - OFFS_W;

  logic [SECT_W-1:0] sect;
  logic [OFFS_W-1:0] offs;
  logic              unused_mid;

  assign sect       = addr_i[ADDR_W-1 -: SECT_W];
  assign offs       = addr_i[OFFS_W-1:0];
  assign unused_mid = ^addr_i[OFFS_W +: MID_W];

  always_comb begin
    id_data_o = '0;
    if (offs == OFFS_W'(0))      id_data_o = with_odd_par(MFR_ID7);
    else if (offs == OFFS_W'(1)) id_data_o = with_odd_par(DEV_ID7);
    else if (offs == OFFS_W'(2)) id_data_o = {{(DATA_W-1){1'b0}}, sect_prot_i[sect]};
  end
endmodule

// File: rtl/flash_toggle.sv
module flash_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_stb_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tog_o <= 1'b0;
    else if (busy_i && rd_stb_i) tog_o <= ~tog_o;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_rdmux_pkg::*;
(
  input  logic              is_prog_i,
  input  logic              prog_bit7_i,
  input  logic              timeout_i,
  input  logic              tog_i,
  output logic [DATA_W-1:0] status_o
);
  always_comb begin
    status_o           = '0;
    // program polls the inverted target bit, erase polls 0
    status_o[POLL_BIT] = is_prog_i ? ~prog_bit7_i : 1'b0;
    status_o[TOG_BIT]  = tog_i;
    status_o[TMO_BIT]  = timeout_i;
  end
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
  import flash_rdmux_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  parameter int OFFS_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       arr_data_i,
  input  logic [DATA_W-1:0]       prog_byte_i,
  input  logic [(1<<SECT_W)-1:0]  sect_prot_i,
  input  logic                    op_done_i,
  input  logic                    op_timeout_i,
  input  logic                    rd_stb_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    toggle_o
);
  rd_mode_e          mode;
  logic              in_op, busy, tog;
  logic [DATA_W-1:0] id_data, status;
  logic              unused_prog;

  assign mode        = rd_mode_e'(mode_i);
  assign in_op       = (mode == MODE_PROG) || (mode == MODE_ERASE);
  assign busy        = in_op && !op_done_i;
  assign unused_prog = ^prog_byte_i[DATA_W-2:0];

  flash_id_src #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .OFFS_W(OFFS_W)
  ) u_id (
    .addr_i     (addr_i),
    .sect_prot_i(sect_prot_i),
    .id_data_o  (id_data)
  );

  flash_toggle u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .rd_stb_i(rd_stb_i),
    .tog_o   (tog)
  );

  flash_status_gen u_stat (
    .is_prog_i  (mode == MODE_PROG),
    .prog_bit7_i(prog_byte_i[DATA_W-1]),
    .timeout_i  (op_timeout_i),
    .tog_i      (tog),
    .status_o   (status)
  );

  always_comb begin
    if (busy)                     rd_data_o = status;
    else if (mode == MODE_AUTOSEL) rd_data_o = id_data;
    else                           rd_data_o = arr_data_i;
  end

  assign toggle_o = tog;
endmodule

// File: rtl/flash_rdmux_chk.sv
module flash_rdmux_chk #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  parameter int OFFS_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [1:0]             mode_i,
  input logic [ADDR_W-1:0]      addr_i,
  input logic [7:0]             arr_data_i,
  input logic [7:0]             prog_byte_i,
  input logic [(1<<SECT_W)-1:0] sect_prot_i,
  input logic                   op_done_i,
  input logic                   op_timeout_i,
  input logic                   rd_stb_i,
  input logic [7:0]             rd_data_o,
  input logic                   toggle_o
);
  logic busy_c, id_rd_c;
  assign busy_c  = mode_i[1] && !op_done_i;
  assign id_rd_c = (mode_i == 2'b01) && (addr_i[OFFS_W-1:1] == '0);

  p_array_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |-> (rd_data_o == arr_data_i));
  p_id_parity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_rd_c |-> ($countones(rd_data_o) % 2 == 1));
  p_prog_poll_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_c && mode_i == 2'b10) |-> (rd_data_o[7] != prog_byte_i[7]));
  p_erase_poll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_c && mode_i == 2'b11) |-> !rd_data_o[7]);
  p_tog_on_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_c |-> (rd_data_o[6] == toggle_o));
  p_tog_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_c && rd_stb_i) |=> (toggle_o != $past(toggle_o)));
  p_tog_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_c && rd_stb_i) |=> $stable(toggle_o));
  p_tmo_bits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_c |-> (rd_data_o[5] == op_timeout_i && rd_data_o[4:0] == 5'd0));
  p_done_fallback_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && op_done_i) |-> (rd_data_o == arr_data_i));
endmodule

bind flash_rdmux flash_rdmux_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .OFFS_W(OFFS_W)
) u_chk (.*);

// File: tb/flash_rdmux_bench.sv
module flash_rdmux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [18:0] addr = '0;
  logic [7:0]  arr = '0, pbyte = '0, prot = '0;
  logic        done = 1'b0, tmo = 1'b0, stb = 1'b0;
  logic [7:0]  rdata;
  logic        tog;
  int          n_chk = 0, n_bad = 0;
  logic        exp_tog = 1'b0;

  always #5 clk = ~clk;

  flash_rdmux u_flash_rdmux (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .addr_i(addr),
    .arr_data_i(arr), .prog_byte_i(pbyte), .sect_prot_i(prot),
    .op_done_i(done), .op_timeout_i(tmo), .rd_stb_i(stb),
    .rd_data_o(rdata), .toggle_o(tog)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_addr(input logic [2:0] s, input logic [7:0] o);
    return {s, 8'hC3, o};
  endfunction

  task automatic t_reset;
    chk("R11 reset toggle", {7'd0, tog}, 8'h00);
  endtask

  task automatic t_array;
    mode = 2'b00;
    foreach (arr_vals[i]) begin
      @(negedge clk); arr = arr_vals[i]; #1;
      chk("R1 array pass", rdata, arr_vals[i]);
    end
  endtask
  logic [7:0] arr_vals [3] = '{8'h3C, 8'hFF, 8'h81};

  task automatic t_ids;
    @(negedge clk); mode = 2'b01; addr = mk_addr(3'd6, 8'h00); #1;
    chk("R2 mfr id", rdata, 8'h01);
    @(negedge clk); addr = mk_addr(3'd2, 8'h01); #1;
    chk("R2 dev id", rdata, 8'hA4);
  endtask

  task automatic t_protect;
    @(negedge clk); mode = 2'b01; prot = 8'b1010_0101; addr = mk_addr(3'd5, 8'h02); #1;
    chk("R3 protected sector 5", rdata, 8'h01);
    @(negedge clk); addr = mk_addr(3'd1, 8'h02); #1;
    chk("R3 unprotected sector 1", rdata, 8'h00);
    @(negedge clk); addr = mk_addr(3'd7, 8'h02); #1;
    chk("R3 protected sector 7", rdata, 8'h01);
  endtask

  task automatic t_other_offs;
    @(negedge clk); mode = 2'b01; addr = mk_addr(3'd0, 8'h07); #1;
    chk("R4 unused offset 07h", rdata, 8'h00);
    @(negedge clk); addr = mk_addr(3'd0, 8'h81); #1;
    chk("R4 unused offset 81h", rdata, 8'h00);
  endtask

  task automatic t_prog_poll;
    @(negedge clk); mode = 2'b10; done = 0; tmo = 0; pbyte = 8'h80; arr = 8'h55; #1;
    chk("R5 prog poll bit7=1", rdata & 8'hBF, 8'h00);
    @(negedge clk); pbyte = 8'h7F; #1;
    chk("R5 prog poll bit7=0", rdata & 8'hBF, 8'h80);
  endtask

  task automatic t_erase_poll;
    @(negedge clk); mode = 2'b11; done = 0; tmo = 0; #1;
    chk("R6 erase poll", rdata & 8'hBF, 8'h00);
  endtask

  task automatic strobe(input logic busy);
    @(negedge clk); stb = 1'b1;
    @(negedge clk); stb = 1'b0;
    if (busy) exp_tog = ~exp_tog;
    #1;
  endtask

  task automatic t_toggle;
    @(negedge clk); mode = 2'b11; done = 0;
    for (int i = 0; i < 3; i++) begin
      strobe(1'b1);
      chk("R7 toggle flips", {7'd0, tog}, {7'd0, exp_tog});
      chk("R7 toggle on dq6", {7'd0, rdata[6]}, {7'd0, exp_tog});
    end
  endtask

  task automatic t_toggle_hold;
    @(negedge clk); mode = 2'b10; done = 1;
    strobe(1'b0);
    chk("R8 hold when done", {7'd0, tog}, {7'd0, exp_tog});
    @(negedge clk); mode = 2'b00; done = 0;
    strobe(1'b0);
    chk("R8 hold in array", {7'd0, tog}, {7'd0, exp_tog});
    @(negedge clk); mode = 2'b01;
    strobe(1'b0);
    chk("R8 hold in autoselect", {7'd0, tog}, {7'd0, exp_tog});
  endtask

  task automatic t_timeout;
    @(negedge clk); mode = 2'b11; done = 0; tmo = 1; #1;
    chk("R9 timeout set", rdata, {1'b0, exp_tog, 1'b1, 5'd0});
    @(negedge clk); mode = 2'b10; pbyte = 8'h00; tmo = 0; #1;
    chk("R9 timeout clear", rdata, {1'b1, exp_tog, 1'b0, 5'd0});
  endtask

  task automatic t_done;
    @(negedge clk); mode = 2'b10; done = 1; arr = 8'h9E; #1;
    chk("R10 program done", rdata, 8'h9E);
    @(negedge clk); mode = 2'b11; arr = 8'hFF; tmo = 1; #1;
    chk("R10 erase done", rdata, 8'hFF);
    tmo = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12; t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_array;
    t_ids;
    t_protect;
    t_other_offs;
    t_prog_poll;
    t_erase_poll;
    t_toggle;
    t_toggle_hold;
    t_timeout;
    t_done;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule